// File: doc/BRIEF.md
# Indirect Host Register Port with Event Interrupt

This block is the host-facing slave side of a communications controller. The host reaches every internal register through two locations on a 16-bit bus. One location is an index register. The other is a data window that reaches whichever register the index names. A chip select qualifies each access. A single port-select line picks the index or the window, and a direction line says whether the block drives the bus (read) or takes data from it (write). Writes take effect on the clock edge where the access strobe is high.

Behind the window are two registers. The first is a status register. It holds five sticky event flags, which the controller core sets with one-cycle pulses and the host clears by writing ones. It also holds an interrupt enable bit at position 9. When the enable bit is set and any flag is set, the block pulls an active-low interrupt output low. The second register is a configuration register. Three of its bits choose how the bus-master side signals: the bus control style, the address strobe style, and whether a shared pin becomes a burst-release input. All other indices are unimplemented.

Top module: `regport_top`

## Requirements
- R1: After reset, the index is 0, all flags are 0, the enable bit is 0, the configuration register is 0 and intN is high.
- R2: A write with portSel high stores wrData[1:0] as the index. A read with portSel high returns the index zero-extended to 16 bits.
- R3: A write or read with portSel low reaches the register the index names. Index 0 is the status register and index 1 is the configuration register.
- R4: busOe is high only while csN is low and readDir is high. Whenever busOe is low, rdData is zero.
- R5: While csN is high, the block ignores accStb, portSel and wrData, so no register changes.
- R6: A pulse on evtSet[i] sets status bit i. The bits are: 0 primitive event, 1 transmit, 2 receive, 3 memory error, 4 missed frame. A set bit stays set until the host clears it.
- R7: Writing status with a one at a flag position clears that flag, and a zero there leaves it unchanged. If an event pulse and a clear reach the same flag in the same cycle, the flag ends set.
- R8: Status bit 9 is a plain read/write interrupt enable. Status bits other than 4:0 and 9 read zero.
- R9: intN is low exactly when the enable bit is 1 and at least one flag is set. It returns high in the cycle after the last flag is cleared or the enable is written to 0.
- R10: Configuration bits 0, 1 and 6 are writable, read back, and appear on busCtlMode, strbMode and burstRelEn. All other configuration bits read zero.
- R11: With the index at 2 or 3, the data window reads zero and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| portSel | input | 1 | High selects the index port, low selects the data window |
| readDir | input | 1 | High means a read (the block drives the bus), low means a write |
| accStb | input | 1 | Write strobe, sampled on the clock edge |
| wrData | input | 16 | Write data from the host |
| evtSet | input | 5 | One-cycle event pulses from the controller core |
| rdData | output | 16 | Read data, zero when not driving |
| busOe | output | 1 | Bus drive enable |
| intN | output | 1 | Active-low interrupt |
| busCtlMode | output | 1 | Bus control style (configuration bit 0) |
| strbMode | output | 1 | Address strobe style (configuration bit 1) |
| burstRelEn | output | 1 | Shared pin used as burst-release input (configuration bit 6) |

## Verification
Every register can be read back at the ports. A corrupted index, flag, enable or configuration bit therefore shows up in the very next read of the affected location. A flag that fails to stick, or a clear that hits the wrong bit, shows in the read that follows the event pulse or the clear. The interrupt output reflects a wrong flag or enable state one cycle after the register update. A decode fault shows as a wrong value or a stray change when the bench sweeps all four indices and reads back the implemented registers.

// File: rtl/regport_pkg.sv
package regport_pkg;
  // Strobes passed from the access decoder to the register datapath.
  typedef struct packed {
    logic idxWr;
    logic statWr;
    logic cfgWr;
    logic rdIdx;
    logic rdStat;
    logic rdCfg;
  } regStb_t;
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int IDX_W    = 2,
  parameter int STAT_IDX = 0,
  parameter int CFG_IDX  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             portSel,
  input  logic             readDir,
  input  logic             accStb,
  input  logic [IDX_W-1:0] idxQ,
  output regStb_t          stb,
  output logic             busOe
);
  localparam logic [IDX_W-1:0] STAT_SEL = IDX_W'(STAT_IDX);
  localparam logic [IDX_W-1:0] CFG_SEL  = IDX_W'(CFG_IDX);

  logic selected;
  logic wrAcc;
  logic rdAcc;
  logic hitStat;
  logic hitCfg;

  always_comb begin
    selected = !csN;
    wrAcc    = selected && !readDir && accStb;
    rdAcc    = selected && readDir;
    hitStat  = (idxQ == STAT_SEL);
    hitCfg   = (idxQ == CFG_SEL);

    stb.idxWr  = wrAcc && portSel;
    stb.statWr = wrAcc && !portSel && hitStat;
    stb.cfgWr  = wrAcc && !portSel && hitCfg;
    stb.rdIdx  = rdAcc && portSel;
    stb.rdStat = rdAcc && !portSel && hitStat;
    stb.rdCfg  = rdAcc && !portSel && hitCfg;
    busOe      = rdAcc;
  end

  // R3: at most one register is written per cycle
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.idxWr, stb.statWr, stb.cfgWr}));
endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int N_EVT  = 5,
  parameter int IE_BIT = 9,
  parameter logic [DATA_W-1:0] CFG_MASK = 16'h0043
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic              busOe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_EVT-1:0]  evtSet,
  output logic [IDX_W-1:0]  idxQ,
  output logic [DATA_W-1:0] cfgQ,
  output logic [DATA_W-1:0] rdData,
  output logic              intN
);
  localparam int IDX_PAD = DATA_W - IDX_W;

  logic [N_EVT-1:0]  flagQ;
  logic              ieQ;
  logic [DATA_W-1:0] statView;

  // index register
  always_ff @(posedge clk) begin
    if (!rstN)          idxQ <= '0;
    else if (stb.idxWr) idxQ <= wrData[IDX_W-1:0];
  end

  // sticky flags: event set takes priority over host clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      for (int i = 0; i < N_EVT; i++) begin
        if (evtSet[i])                     flagQ[i] <= 1'b1;
        else if (stb.statWr && wrData[i])  flagQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ieQ <= 1'b0;
    else if (stb.statWr) ieQ <= wrData[IE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cfgQ <= '0;
    else if (stb.cfgWr) cfgQ <= wrData & CFG_MASK;
  end

  always_comb begin
    statView                = '0;
    statView[N_EVT-1:0]     = flagQ;
    statView[IE_BIT]        = ieQ;
  end

  always_comb begin
    rdData = '0;
    if (busOe) begin
      if (stb.rdIdx)       rdData = {{IDX_PAD{1'b0}}, idxQ};
      else if (stb.rdStat) rdData = statView;
      else if (stb.rdCfg)  rdData = cfgQ;
    end
  end

  assign intN = !(ieQ && (|flagQ));

  // R2: index holds unless written through the index port
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.idxWr |=> $stable(idxQ));

  // R6: every pulsed event is visible as a set flag one cycle later
  p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((flagQ & $past(evtSet)) == $past(evtSet)));

  // R11: without a decoded register write, enable and config stay put
  p_no_stray_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.statWr || stb.cfgWr) |=> ($stable(cfgQ) && $stable(ieQ)));

  // R4: bus data is quiet while not driving
  p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (rdData == '0));
endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int IDX_W        = 2,
  parameter int N_EVT        = 5,
  parameter int IE_BIT       = 9,
  parameter int STAT_IDX     = 0,
  parameter int CFG_IDX      = 1,
  parameter int BUSCTL_BIT   = 0,
  parameter int STRB_BIT     = 1,
  parameter int BURSTREL_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              portSel,
  input  logic              readDir,
  input  logic              accStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_EVT-1:0]  evtSet,
  output logic [DATA_W-1:0] rdData,
  output logic              busOe,
  output logic              intN,
  output logic              busCtlMode,
  output logic              strbMode,
  output logic              burstRelEn
);
  localparam logic [DATA_W-1:0] CFG_MASK =
      (DATA_W'(1) << BUSCTL_BIT) | (DATA_W'(1) << STRB_BIT) | (DATA_W'(1) << BURSTREL_BIT);

  regStb_t           stb;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] cfgQ;

  regport_ctrl #(.IDX_W(IDX_W), .STAT_IDX(STAT_IDX), .CFG_IDX(CFG_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .portSel(portSel), .readDir(readDir),
    .accStb(accStb), .idxQ(idxQ), .stb(stb), .busOe(busOe)
  );

  regport_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_EVT(N_EVT), .IE_BIT(IE_BIT),
               .CFG_MASK(CFG_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busOe(busOe), .wrData(wrData),
    .evtSet(evtSet), .idxQ(idxQ), .cfgQ(cfgQ), .rdData(rdData), .intN(intN)
  );

  assign busCtlMode = cfgQ[BUSCTL_BIT];
  assign strbMode   = cfgQ[STRB_BIT];
  assign burstRelEn = cfgQ[BURSTREL_BIT];
endmodule

// File: tb/regport_top_bench.sv
`timescale 1ns/1ps
module regport_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, portSel = 1'b0, readDir = 1'b0, accStb = 1'b0;
  logic [15:0] wrData = '0;
  logic [4:0]  evtSet = '0;
  logic [15:0] rdData;
  logic busOe, intN, busCtlMode, strbMode, burstRelEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regport_top u_regport_top (
    .clk(clk), .rstN(rstN), .csN(csN), .portSel(portSel), .readDir(readDir),
    .accStb(accStb), .wrData(wrData), .evtSet(evtSet), .rdData(rdData),
    .busOe(busOe), .intN(intN), .busCtlMode(busCtlMode), .strbMode(strbMode),
    .burstRelEn(burstRelEn)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic portWrite(input logic sel, input logic [15:0] d);
    @(negedge clk);
    csN = 1'b0; portSel = sel; readDir = 1'b0; wrData = d; accStb = 1'b1;
    @(negedge clk);
    accStb = 1'b0; csN = 1'b1;
  endtask

  task automatic portRead(input logic sel, output logic [15:0] d);
    @(negedge clk);
    csN = 1'b0; portSel = sel; readDir = 1'b1;
    #1 d = rdData;
    csN = 1'b1; readDir = 1'b0;
  endtask

  task automatic regWrite(input int idx, input logic [15:0] d);
    portWrite(1'b1, 16'(idx));
    portWrite(1'b0, d);
  endtask

  task automatic regRead(input int idx, output logic [15:0] d);
    portWrite(1'b1, 16'(idx));
    portRead(1'b0, d);
  endtask

  task automatic pulseEvt(input logic [4:0] v);
    @(negedge clk);
    evtSet = v;
    @(negedge clk);
    evtSet = '0;
  endtask

  initial begin
    logic [15:0] d;
    logic [15:0] cfgExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1 intN", 16'(intN), 16'd1);
    check("R1 cfg pins", 16'({burstRelEn, strbMode, busCtlMode}), 16'd0);
    // R4 idle bus
    check("R4 idle oe", 16'(busOe), 16'd0);
    check("R4 idle data", rdData, 16'd0);
    portRead(1'b1, d); check("R1 index", d, 16'd0);
    portRead(1'b0, d); check("R1 status", d, 16'd0);
    regRead(1, d);     check("R1 config", d, 16'd0);

    // R2 index port sweep, upper bits dropped
    for (int i = 0; i < 4; i++) begin
      portWrite(1'b1, 16'hFFF0 | 16'(i));
      portRead(1'b1, d);
      check("R2 index readback", d, 16'(i));
    end

    // R4 output enable during a write and during a read
    @(negedge clk);
    csN = 1'b0; readDir = 1'b0; portSel = 1'b1; #1;
    check("R4 oe on write", 16'(busOe), 16'd0);
    check("R4 data on write", rdData, 16'd0);
    readDir = 1'b1; #1;
    check("R4 oe on read", 16'(busOe), 16'd1);
    csN = 1'b1; readDir = 1'b0; #1;
    check("R4 oe deselected", 16'(busOe), 16'd0);

    // R10 R3 config walking ones and all ones
    for (int b = 0; b <= 16; b++) begin
      logic [15:0] pat;
      pat = (b == 16) ? 16'hFFFF : (16'd1 << b);
      cfgExp = pat & 16'h0043;
      regWrite(1, pat);
      portRead(1'b0, d);
      check("R10 config readback", d, cfgExp);
      check("R10 config pins", 16'({burstRelEn, strbMode, busCtlMode}),
            16'({cfgExp[6], cfgExp[1], cfgExp[0]}));
    end
    // config now 0x0043

    // R5 chip select high blocks writes
    @(negedge clk);
    csN = 1'b1; portSel = 1'b0; readDir = 1'b0; wrData = 16'h0000; accStb = 1'b1;
    @(negedge clk);
    portSel = 1'b1; wrData = 16'h0002;
    @(negedge clk);
    accStb = 1'b0;
    portRead(1'b1, d); check("R5 index kept", d, 16'd1);
    portRead(1'b0, d); check("R5 config kept", d, 16'h0043);

    // R8 enable bit and unused status bits
    regWrite(0, 16'hFFE0);
    portRead(1'b0, d); check("R8 enable set", d, 16'h0200);
    portWrite(1'b0, 16'h0000);
    portRead(1'b0, d); check("R8 enable clear", d, 16'h0000);

    // R6 R7 event sweep with enable off
    for (int v = 0; v < 32; v++) begin
      pulseEvt(5'(v));
      portRead(1'b0, d); check("R6 flags set", d, 16'(v));
      check("R9 no int when disabled", 16'(intN), 16'd1);
      portWrite(1'b0, 16'h0000);
      portRead(1'b0, d); check("R7 zero write keeps", d, 16'(v));
      portWrite(1'b0, 16'h001F);
      portRead(1'b0, d); check("R7 clear all", d, 16'd0);
    end

    // R7 partial clear sweep
    for (int m = 0; m < 32; m++) begin
      pulseEvt(5'h1F);
      portWrite(1'b0, 16'(m));
      portRead(1'b0, d);
      check("R7 partial clear", d, 16'(5'h1F & ~5'(m)));
      portWrite(1'b0, 16'h001F);
    end

    // R9 interrupt per flag
    portWrite(1'b0, 16'h0200);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); check("R9 idle high", 16'(intN), 16'd1);
      pulseEvt(5'(1 << k));
      check("R9 asserted", 16'(intN), 16'd0);
      portWrite(1'b0, 16'h0200 | 16'(1 << k));
      check("R9 released", 16'(intN), 16'd1);
    end
    pulseEvt(5'b00100);
    portWrite(1'b0, 16'h0000);
    check("R9 release by enable", 16'(intN), 16'd1);
    portWrite(1'b0, 16'h0200);
    check("R9 re-enable", 16'(intN), 16'd0);
    portWrite(1'b0, 16'h001F);

    // R7 set beats clear in the same cycle
    @(negedge clk);
    csN = 1'b0; portSel = 1'b0; readDir = 1'b0; wrData = 16'h0004; accStb = 1'b1;
    evtSet = 5'b00100;
    @(negedge clk);
    accStb = 1'b0; csN = 1'b1; evtSet = '0;
    portRead(1'b0, d); check("R7 set wins", d, 16'h0004);
    portWrite(1'b0, 16'h001F);

    // R11 unimplemented indices
    regWrite(0, 16'h0200);
    pulseEvt(5'b10001);
    for (int u = 2; u < 4; u++) begin
      regWrite(u, 16'hFFFF);
      portRead(1'b0, d); check("R11 reads zero", d, 16'd0);
      portWrite(1'b0, 16'h0000);
    end
    regRead(0, d); check("R11 status untouched", d, 16'h0211);
    regRead(1, d); check("R11 config untouched", d, 16'h0043);
    check("R11 int still low", 16'(intN), 16'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule